// File: doc/BRIEF.md
# Bounded Random TLB Victim Index Counter

This block picks which translation-buffer entry a random-replacement write overwrites. It keeps a small down-counter that moves by one each time an instruction retires. The counter cycles between a lower bound and a fixed upper bound. The lower bound is the number of wired (locked) entries, and software can change it at run time. The upper bound is the entry count minus one.

The current index is returned as a read-only register, with all bits above the index reading as zero. The wired count is held inside the block and can be read back. Writing a new wired count, or resetting the block, sends the counter back to the upper bound.

Top module: `tlbRandomIndex`

## Requirements
- R1: `victimReg` carries the index in bits 5:0, and every bit above the index reads as zero.
- R2: A retire pulse with no wired write decrements the index by exactly one, as long as the index is greater than the wired count.
- R3: The index never exceeds TOP (ENTRIES-1). While the wired count is at most TOP, the index is never below the wired count.
- R4: After reset the index equals TOP and the wired count reads zero.
- R5: A wired write loads the index with TOP on the next edge. A retire in the same cycle has no further effect.
- R6: A retire while the index is less than or equal to the wired count reloads TOP instead of decrementing.
- R7: While the wired count is greater than TOP, the index stays at TOP through retires.
- R8: A wired write stores its 6-bit data, and `wiredQ` returns that value from the next cycle on.
- R9: In a cycle with neither retire nor wired write, the index holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| retire | input | 1 | One instruction retired this cycle |
| wiredWe | input | 1 | Write strobe for the wired count |
| wiredWdata | input | IDX_W | New wired count |
| wiredQ | output | IDX_W | Current wired count |
| victimIdx | output | IDX_W | Current replacement index |
| victimReg | output | REG_W | Index zero-extended to register width |

## Verification
The bench lowers the wired count to zero and walks the index all the way down to 0. One more retire must then wrap to 63. A design that compares with the wrong bound would underflow at this point, or wrap one step early. A retire arriving in the same cycle as a wired write must leave the index at the top; a wrong priority would show one below it. A second instance with 48 entries is loaded with a wired count above its top. Its index must stay pinned at 47, so a design that decrements past the bound or wraps to a value outside the table is caught.

// File: rtl/tlbRndPkg.sv
package tlbRndPkg;
  typedef struct packed {
    logic reload;
    logic step;
  } ctlStrobesT;
endpackage

// File: rtl/tlbRndCtl.sv
module tlbRndCtl
  import tlbRndPkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retire,
  input  logic             wiredWe,
  input  logic [IDX_W-1:0] wiredWdata,
  output logic [IDX_W-1:0] wiredQ,
  output ctlStrobesT       strobes
);
  logic [IDX_W-1:0] wiredR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        wiredR <= '0;
    else if (wiredWe) wiredR <= wiredWdata;
  end

  // a wired write outranks a retire in the same cycle
  always_comb begin
    strobes.reload = wiredWe;
    strobes.step   = retire & ~wiredWe;
  end

  assign wiredQ = wiredR;

  a_r8_wired_store: assert property (@(posedge clk) disable iff (!rstN)
    wiredWe |=> wiredQ == $past(wiredWdata));
  a_r8_wired_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wiredWe |=> $stable(wiredQ));
endmodule

// File: rtl/tlbRndDp.sv
module tlbRndDp
  import tlbRndPkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int ENTRIES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobesT       strobes,
  input  logic [IDX_W-1:0] wired,
  output logic [IDX_W-1:0] cnt
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] cntR;
  logic             wrapNow;

  // wrap when a decrement would fall below the bound, or the bound is beyond the table
  assign wrapNow = (wired > TOP) || (cntR <= wired);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntR <= TOP;
    else if (strobes.reload) cntR <= TOP;
    else if (strobes.step)   cntR <= wrapNow ? TOP : cntR - 1'b1;
  end

  assign cnt = cntR;

  a_r3_upper: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= TOP);
  a_r3_lower: assert property (@(posedge clk) disable iff (!rstN)
    (wired <= TOP) |-> (cnt >= wired));
  a_r5_reload: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reload |=> cnt == TOP);
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.reload && cnt > wired && wired <= TOP) |=> cnt == $past(cnt) - 1'b1);
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.reload && cnt <= wired) |=> cnt == TOP);
  a_r7_pinned: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && wired > TOP) |=> cnt == TOP);
  a_r9_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.step && !strobes.reload) |=> $stable(cnt));
endmodule

// File: rtl/tlbRandomIndex.sv
module tlbRandomIndex
  import tlbRndPkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int ENTRIES = 64,
  parameter int REG_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retire,
  input  logic             wiredWe,
  input  logic [IDX_W-1:0] wiredWdata,
  output logic [IDX_W-1:0] wiredQ,
  output logic [IDX_W-1:0] victimIdx,
  output logic [REG_W-1:0] victimReg
);
  localparam int PAD_W = REG_W - IDX_W;

  ctlStrobesT       strobes;
  logic [IDX_W-1:0] wiredVal;
  logic [IDX_W-1:0] cnt;

  tlbRndCtl #(.IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .retire(retire), .wiredWe(wiredWe),
    .wiredWdata(wiredWdata), .wiredQ(wiredVal), .strobes(strobes)
  );

  tlbRndDp #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wired(wiredVal), .cnt(cnt)
  );

  assign wiredQ    = wiredVal;
  assign victimIdx = cnt;
  assign victimReg = {{PAD_W{1'b0}}, cnt};

  a_r1_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    victimReg[REG_W-1:IDX_W] == '0);
endmodule

// File: tb/tlbRandomIndex_tb.sv
module tlbRandomIndex_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic       retA = 0, weA = 0, retB = 0, weB = 0;
  logic [5:0] wdA = 0, wdB = 0;
  logic [5:0] wqA, idxA, wqB, idxB;
  logic [31:0] regA, regB;

  int nChk = 0, nFail = 0;
  bit done = 0;

  tlbRandomIndex u_dut (
    .clk(clk), .rstN(rstN), .retire(retA), .wiredWe(weA), .wiredWdata(wdA),
    .wiredQ(wqA), .victimIdx(idxA), .victimReg(regA)
  );

  tlbRandomIndex #(.ENTRIES(48)) u_dut48 (
    .clk(clk), .rstN(rstN), .retire(retB), .wiredWe(weB), .wiredWdata(wdB),
    .wiredQ(wqB), .victimIdx(idxB), .victimReg(regB)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at a negedge, let one posedge pass, release at the following negedge
  task automatic applyA(input logic r, input logic w, input logic [5:0] d);
    retA = r; weA = w; wdA = d;
    @(negedge clk);
    retA = 0; weA = 0;
  endtask

  task automatic applyB(input logic r, input logic w, input logic [5:0] d);
    retB = r; weB = w; wdB = d;
    @(negedge clk);
    retB = 0; weB = 0;
  endtask

  // {retire, wiredWe, wdata, expected index, expected wired}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b1, 6'd60, 6'd63, 6'd60},
    {1'b1, 1'b0, 6'd0,  6'd62, 6'd60},
    {1'b1, 1'b0, 6'd0,  6'd61, 6'd60},
    {1'b1, 1'b0, 6'd0,  6'd60, 6'd60},
    {1'b1, 1'b0, 6'd0,  6'd63, 6'd60},
    {1'b0, 1'b0, 6'd0,  6'd63, 6'd60},
    {1'b1, 1'b1, 6'd62, 6'd63, 6'd62},
    {1'b1, 1'b0, 6'd0,  6'd62, 6'd62},
    {1'b1, 1'b0, 6'd0,  6'd63, 6'd62},
    {1'b0, 1'b1, 6'd0,  6'd63, 6'd0},
    {1'b1, 1'b0, 6'd0,  6'd62, 6'd0},
    {1'b1, 1'b0, 6'd0,  6'd61, 6'd0}
  };

  initial begin
    #1_000_000;
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R4 reset index", int'(idxA), 63);
    check("R4 reset wired", int'(wqA), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R2 R5 R6 R8 R9, plus R1 zero fill each step
    for (int i = 0; i < NV; i++) begin
      applyA(VEC[i][19], VEC[i][18], VEC[i][17:12]);
      check("R2/R5/R6/R9 index", int'(idxA), int'(VEC[i][11:6]));
      check("R8 wired readback", int'(wqA), int'(VEC[i][5:0]));
      check("R1 upper bits", int'(regA[31:6]), 0);
      check("R1 low bits", int'(regA[5:0]), int'(VEC[i][11:6]));
    end

    // R2 full descent to 0 with zero wired entries
    for (int e = 60; e >= 0; e--) begin
      applyA(1'b1, 1'b0, 6'd0);
      check("R2 descent", int'(idxA), e);
    end
    // R6 wrap from 0
    applyA(1'b1, 1'b0, 6'd0);
    check("R6 wrap from zero", int'(idxA), 63);
    // R3 bound held across idle cycles
    applyA(1'b0, 1'b0, 6'd0);
    check("R9 idle hold", int'(idxA), 63);

    // R4 mid-run reset
    applyA(1'b0, 1'b1, 6'd30);
    applyA(1'b1, 1'b0, 6'd0);
    check("R2 before reset", int'(idxA), 62);
    rstN = 1'b0;
    #2;
    check("R4 reset index", int'(idxA), 63);
    check("R4 reset wired", int'(wqA), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R7 on a 48-entry instance: wired above top pins the index
    check("R4 small reset", int'(idxB), 47);
    applyB(1'b0, 1'b1, 6'd50);
    check("R8 small wired", int'(wqB), 50);
    applyB(1'b1, 1'b0, 6'd0);
    check("R7 pinned", int'(idxB), 47);
    applyB(1'b1, 1'b0, 6'd0);
    check("R7 pinned again", int'(idxB), 47);
    applyB(1'b0, 1'b1, 6'd46);
    applyB(1'b1, 1'b0, 6'd0);
    check("R2 small step", int'(idxB), 46);
    applyB(1'b1, 1'b0, 6'd0);
    check("R6 small wrap", int'(idxB), 47);
    check("R3 small range", int'(idxB <= 6'd47 && idxB >= wqB), 1);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule